// File: doc/BRIEF.md
# Running CRC Correct-Position Tracker

This block watches a received byte stream that starts right after the start-of-frame delimiter. It feeds the stream into two CRC engines at the same time, an 8-bit one and a 32-bit one. After every byte, each engine checks whether its register now holds the value that an intact frame leaves behind. Whenever that check passes, the block records the current 12-bit byte position for that engine. When the frame has ended, each recorded position is therefore the last byte at which that CRC was valid.

Firmware reads the two positions and compares them with the length given in the frame header. A position that does not agree with that length means a corrupt or truncated frame. A programmable count of leading bytes, such as a header that the CRC does not cover, is still counted but is kept out of both CRC calculations. Each position is presented as a low byte register and a high byte register.

Top module: `crc_pos_tracker`

## Requirements
- R1: While reset is asserted, and afterwards until the first byte is accepted, all four position registers read 0.
- R2: A cycle with `frame_start_i` high clears the byte counter, both CRC registers and both captured positions. A byte presented with `byte_vld_i` in that same cycle is dropped and is not counted.
- R3: The position of each accepted byte is one more than the previous one. The first byte after a frame start has position 1. Every byte is counted, including the CRC bytes themselves.
- R4: The byte position saturates at 4095 (0xFFF) and does not wrap. Bytes accepted after that point all carry position 4095.
- R5: Bytes at positions 1 to `skip_len_i` update neither CRC engine and never cause a capture. The byte at position `skip_len_i`+1 is the first one that enters both engines.
- R6: The 8-bit engine uses polynomial 0x07, most significant bit first, with a zero preset. It is correct when its register is 0x00. Appending the 8-bit CRC of the covered bytes therefore makes it correct.
- R7: The 32-bit engine uses polynomial 0x04C11DB7 in reflected form, least significant bit first, with an all-ones preset. It is correct when its register holds the residue 0xC704DD7B in normal bit order, which is 0xDEBB20E3 in reflected order. Appending the inverted CRC, low byte first, makes it correct.
- R8: On each byte that enters an engine and leaves it correct, that engine's captured position takes the byte's position. Any other byte leaves the captured position unchanged, so a later correct byte overwrites an earlier capture.
- R9: Each low register holds position bits 7:0. Each high register holds position bits 11:8 in its bits 3:0. Bits 7:4 of each high register, which are reserved, read 0.
- R10: In cycles with neither a byte nor a frame start, no position register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_start_i | input | 1 | One-cycle pulse marking the end of the start-of-frame delimiter |
| byte_vld_i | input | 1 | Strobe: `byte_i` carries a received byte |
| byte_i | input | 8 | Received byte |
| skip_len_i | input | 12 | Number of leading counted bytes kept out of both CRC engines |
| c8_pos_lo_o | output | 8 | 8-bit CRC correct position, bits 7:0 |
| c8_pos_hi_o | output | 8 | 8-bit CRC correct position, bits 11:8 in bits 3:0 |
| c32_pos_lo_o | output | 8 | 32-bit CRC correct position, bits 7:0 |
| c32_pos_hi_o | output | 8 | 32-bit CRC correct position, bits 11:8 in bits 3:0 |

## Verification
The bench first sends zero bytes after a nonzero skip count. A zero-preset 8-bit CRC already reads as correct, so a design that evaluates skipped bytes would capture a header position. It then runs more than 4095 bytes, where a wrapping counter would fall back to small positions and split the high and low registers incorrectly. It also overwrites a valid capture with later correct bytes, which exposes a design that keeps only the first hit. Finally, it raises a frame start together with a byte strobe, which exposes a design that counts the colliding byte or feeds it into a CRC. Known-answer frames with a header skip confirm the bit order and residue of each polynomial.

// File: rtl/crc_pos_pkg.sv
package crc_pos_pkg;

  // Bit order in which an engine consumes each byte
  typedef enum logic {
    CRC_MSB_FIRST = 1'b0,
    CRC_LSB_FIRST = 1'b1
  } crc_order_e;

endpackage

// File: rtl/crc_pos_rst_sync.sv
module crc_pos_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/crc_pos_counter.sv
module crc_pos_counter #(
  parameter int POS_W  = 12,
  parameter int SKIP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              vld_i,
  input  logic [SKIP_W-1:0] skip_i,
  output logic [POS_W-1:0]  pos_next_o,
  output logic              feed_o,
  output logic [POS_W-1:0]  cnt_o
);

  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam int CMP_W = (POS_W > SKIP_W) ? POS_W : SKIP_W;

  logic [POS_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [POS_W-1:0] pos_next;

  // Saturating increment
  always_comb begin
    if (cnt_q == POS_MAX) begin
      pos_next = POS_MAX;
    end else begin
      pos_next = cnt_q + POS_W'(1);
    end
  end

  // A byte enters the engines only past the skipped prefix
  always_comb begin
    feed_o = vld_i && !clr_i && (CMP_W'(pos_next) > CMP_W'(skip_i));
  end

  always_comb begin
    cnt_en = clr_i || vld_i;
    if (clr_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = pos_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign pos_next_o = pos_next;
  assign cnt_o      = cnt_q;

endmodule

// File: rtl/crc_pos_lane.sv
module crc_pos_lane
  import crc_pos_pkg::*;
#(
  parameter int         W      = 8,
  parameter logic [W-1:0] POLY   = 8'h07,
  parameter logic [W-1:0] PRESET = '0,
  parameter logic [W-1:0] RESID  = '0,
  parameter crc_order_e ORDER  = CRC_MSB_FIRST,
  parameter int         POS_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             feed_i,
  input  logic [7:0]       byte_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [W-1:0]     crc_o,
  output logic [POS_W-1:0] pos_o
);

  function automatic logic [W-1:0] rev_w(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      r[i] = v[W-1-i];
    end
    return r;
  endfunction

  // Residue is given in normal order; a reflected engine holds it reversed
  localparam logic [W-1:0] MATCH = (ORDER == CRC_LSB_FIRST) ? rev_w(RESID) : RESID;

  logic [W-1:0]     crc_q, crc_d, crc_upd;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             crc_en, pos_en, hit;

  generate
    if (ORDER == CRC_LSB_FIRST) begin : g_lsb
      localparam logic [W-1:0] POLY_R = rev_w(POLY);
      always_comb begin
        logic [W-1:0] c;
        c      = crc_q;
        c[7:0] = c[7:0] ^ byte_i;
        for (int k = 0; k < 8; k++) begin
          c = c[0] ? ((c >> 1) ^ POLY_R) : (c >> 1);
        end
        crc_upd = c;
      end
    end else begin : g_msb
      always_comb begin
        logic [W-1:0] c;
        c           = crc_q;
        c[W-1 -: 8] = c[W-1 -: 8] ^ byte_i;
        for (int k = 0; k < 8; k++) begin
          c = c[W-1] ? ((c << 1) ^ POLY) : (c << 1);
        end
        crc_upd = c;
      end
    end
  endgenerate

  always_comb begin
    hit    = feed_i && (crc_upd == MATCH);
    crc_en = clr_i || feed_i;
    pos_en = clr_i || hit;
    crc_d  = clr_i ? PRESET : crc_upd;
    pos_d  = clr_i ? '0 : pos_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= PRESET;
    end else if (crc_en) begin
      crc_q <= crc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_en) begin
      pos_q <= pos_d;
    end
  end

  assign crc_o = crc_q;
  assign pos_o = pos_q;

endmodule

// File: rtl/crc_pos_tracker.sv
module crc_pos_tracker
  import crc_pos_pkg::*;
#(
  parameter int POS_W  = 12,
  parameter int SKIP_W = 12
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              frame_start_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [SKIP_W-1:0] skip_len_i,
  output logic [7:0]        c8_pos_lo_o,
  output logic [7:0]        c8_pos_hi_o,
  output logic [7:0]        c32_pos_lo_o,
  output logic [7:0]        c32_pos_hi_o
);

  logic             rst_sync_n;
  logic             feed;
  logic [POS_W-1:0] pos_next;
  logic [POS_W-1:0] pos_cnt;
  logic [7:0]       crc8;
  logic [31:0]      crc32;
  logic [POS_W-1:0] pos8;
  logic [POS_W-1:0] pos32;

  crc_pos_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_sync_n)
  );

  crc_pos_counter #(
    .POS_W  (POS_W),
    .SKIP_W (SKIP_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr_i      (frame_start_i),
    .vld_i      (byte_vld_i),
    .skip_i     (skip_len_i),
    .pos_next_o (pos_next),
    .feed_o     (feed),
    .cnt_o      (pos_cnt)
  );

  crc_pos_lane #(
    .W      (8),
    .POLY   (8'h07),
    .PRESET (8'h00),
    .RESID  (8'h00),
    .ORDER  (CRC_MSB_FIRST),
    .POS_W  (POS_W)
  ) u_lane8 (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (frame_start_i),
    .feed_i (feed),
    .byte_i (byte_i),
    .pos_i  (pos_next),
    .crc_o  (crc8),
    .pos_o  (pos8)
  );

  crc_pos_lane #(
    .W      (32),
    .POLY   (32'h04C11DB7),
    .PRESET (32'hFFFFFFFF),
    .RESID  (32'hC704DD7B),
    .ORDER  (CRC_LSB_FIRST),
    .POS_W  (POS_W)
  ) u_lane32 (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (frame_start_i),
    .feed_i (feed),
    .byte_i (byte_i),
    .pos_i  (pos_next),
    .crc_o  (crc32),
    .pos_o  (pos32)
  );

  // Byte-wide register view; reserved high bits are driven to zero
  assign c8_pos_lo_o  = pos8[7:0];
  assign c8_pos_hi_o  = 8'(pos8 >> 8);
  assign c32_pos_lo_o = pos32[7:0];
  assign c32_pos_hi_o = 8'(pos32 >> 8);

endmodule

// File: rtl/crc_pos_tracker_chk.sv
module crc_pos_tracker_chk #(
  parameter int POS_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sof,
  input logic             vld,
  input logic             feed,
  input logic [POS_W-1:0] cnt,
  input logic [7:0]       crc8,
  input logic [31:0]      crc32,
  input logic [POS_W-1:0] p8,
  input logic [POS_W-1:0] p32,
  input logic [7:0]       hi8,
  input logic [7:0]       hi32
);

  localparam logic [POS_W-1:0] CNT_MAX = {POS_W{1'b1}};

  AST_SOF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (cnt == '0) && (p8 == '0) && (p32 == '0)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !sof && cnt != CNT_MAX) |=> (cnt == $past(cnt) + POS_W'(1))); // R3

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && cnt == CNT_MAX) |=> (cnt == CNT_MAX)); // R4

  AST_SKIP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!feed && !sof) |=> ($stable(crc8) && $stable(crc32))); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld && !sof) |=> ($stable(p8) && $stable(p32))); // R10

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hi8[7:4] == 4'h0) && (hi32[7:4] == 4'h0)); // R9

endmodule

bind crc_pos_tracker crc_pos_tracker_chk #(.POS_W(POS_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .sof   (frame_start_i),
  .vld   (byte_vld_i),
  .feed  (feed),
  .cnt   (pos_cnt),
  .crc8  (crc8),
  .crc32 (crc32),
  .p8    (pos8),
  .p32   (pos32),
  .hi8   (c8_pos_hi_o),
  .hi32  (c32_pos_hi_o)
);

// File: tb/test_crc_pos_tracker.sv
`timescale 1ns/1ps
module test_crc_pos_tracker;

  localparam real CLK_HALF = 2.5;

  logic        clk;
  logic        arst_n;
  logic        frame_start_i;
  logic        byte_vld_i;
  logic [7:0]  byte_i;
  logic [11:0] skip_len_i;
  logic [7:0]  c8_pos_lo_o, c8_pos_hi_o, c32_pos_lo_o, c32_pos_hi_o;

  int n_cmp;
  int n_bad;
  bit done;

  // reference state built from the requirements
  int          m_pos;
  int          m_skip;
  logic [7:0]  m_c8;
  logic [31:0] m_c32;
  int          m_p8;
  int          m_p32;

  crc_pos_tracker i_crc_pos_tracker (
    .clk           (clk),
    .arst_n        (arst_n),
    .frame_start_i (frame_start_i),
    .byte_vld_i    (byte_vld_i),
    .byte_i        (byte_i),
    .skip_len_i    (skip_len_i),
    .c8_pos_lo_o   (c8_pos_lo_o),
    .c8_pos_hi_o   (c8_pos_hi_o),
    .c32_pos_lo_o  (c32_pos_lo_o),
    .c32_pos_hi_o  (c32_pos_hi_o)
  );

  initial clk = 1'b0;
  always #(CLK_HALF) clk = ~clk;

  function automatic logic [7:0] ref_crc8(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  function automatic logic [31:0] ref_crc32(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    chk(req, "c8 lo",  int'(c8_pos_lo_o),  m_p8 & 8'hFF);
    chk(req, "c8 hi",  int'(c8_pos_hi_o),  (m_p8 >> 8) & 8'h0F);
    chk(req, "c32 lo", int'(c32_pos_lo_o), m_p32 & 8'hFF);
    chk(req, "c32 hi", int'(c32_pos_hi_o), (m_p32 >> 8) & 8'h0F);
  endtask

  task automatic model_clear();
    m_pos = 0; m_c8 = 8'h00; m_c32 = 32'hFFFFFFFF; m_p8 = 0; m_p32 = 0;
  endtask

  task automatic start_frame(input int skip);
    @(negedge clk);
    skip_len_i    = 12'(skip);
    frame_start_i = 1'b1;
    @(negedge clk);
    frame_start_i = 1'b0;
    m_skip = skip;
    model_clear();
  endtask

  task automatic send_byte(input logic [7:0] b);
    int p;
    @(negedge clk);
    byte_vld_i = 1'b1;
    byte_i     = b;
    @(negedge clk);
    byte_vld_i = 1'b0;
    p = (m_pos == 4095) ? 4095 : m_pos + 1;
    m_pos = p;
    if (p > m_skip) begin
      m_c8  = ref_crc8(m_c8, b);
      m_c32 = ref_crc32(m_c32, b);
      if (m_c8 == 8'h00) m_p8 = p;
      if (m_c32 == 32'hDEBB20E3) m_p32 = p;
    end
  endtask

  task automatic send_digits();
    for (int i = 0; i < 9; i++) send_byte(8'h31 + 8'(i));
  endtask

  task automatic t_reset();
    chk_regs("R1");
  endtask

  task automatic t_ref_known();
    logic [7:0]  c8;
    logic [31:0] c32;
    c8 = 8'h00; c32 = 32'hFFFFFFFF;
    for (int i = 0; i < 9; i++) begin
      c8  = ref_crc8(c8, 8'h31 + 8'(i));
      c32 = ref_crc32(c32, 8'h31 + 8'(i));
    end
    chk("R6", "ref crc8 check value", int'(c8), 8'hF4);
    chk("R7", "ref crc32 check value", int'(~c32), 32'hCBF43926);
  endtask

  task automatic t_crc8_frame();
    start_frame(0);
    send_digits();
    send_byte(8'hF4);
    chk("R6", "c8 position after check byte", m_p8, 10);
    chk_regs("R6");
    chk_regs("R3");
  endtask

  task automatic t_crc32_header();
    start_frame(4);
    send_byte(8'hAA); send_byte(8'hBB); send_byte(8'hCC); send_byte(8'hDD);
    send_digits();
    send_byte(8'h26); send_byte(8'h39); send_byte(8'hF4); send_byte(8'hCB);
    chk("R7", "c32 position after fcs", m_p32, 17);
    chk_regs("R7");
    chk_regs("R5");
  endtask

  task automatic t_skip_zero();
    start_frame(3);
    for (int i = 0; i < 3; i++) begin
      send_byte(8'h00);
      chk("R5", "c8 lo during skipped zero bytes", int'(c8_pos_lo_o), 0);
    end
    send_byte(8'h00);
    chk("R5", "c8 lo at first fed byte", int'(c8_pos_lo_o), 4);
    start_frame(0);
    send_byte(8'h00);
    chk("R3", "c8 lo first byte is position 1", int'(c8_pos_lo_o), 1);
  endtask

  task automatic t_last_correct();
    start_frame(0);
    send_digits();
    send_byte(8'hF4);
    chk("R8", "c8 lo first capture", int'(c8_pos_lo_o), 10);
    send_byte(8'h00);
    chk("R8", "c8 lo overwritten by later hit", int'(c8_pos_lo_o), 11);
    send_byte(8'h55);
    chk("R8", "c8 lo held on miss", int'(c8_pos_lo_o), 11);
    chk_regs("R8");
  endtask

  task automatic t_idle();
    repeat (10) @(negedge clk);
    chk_regs("R10");
  endtask

  task automatic t_frame_start();
    start_frame(0);
    chk_regs("R2");
    chk("R2", "c8 lo cleared", int'(c8_pos_lo_o), 0);
    // frame start and byte in the same cycle: byte dropped
    @(negedge clk);
    frame_start_i = 1'b1;
    byte_vld_i    = 1'b1;
    byte_i        = 8'h00;
    @(negedge clk);
    frame_start_i = 1'b0;
    byte_vld_i    = 1'b0;
    model_clear();
    chk("R2", "c8 lo after colliding byte", int'(c8_pos_lo_o), 0);
    send_byte(8'h00);
    chk("R2", "c8 lo next byte is position 1", int'(c8_pos_lo_o), 1);
  endtask

  task automatic t_saturate();
    start_frame(0);
    for (int i = 0; i < 256; i++) send_byte(8'h00);
    chk("R9", "c8 lo at 0x100", int'(c8_pos_lo_o), 8'h00);
    chk("R9", "c8 hi at 0x100", int'(c8_pos_hi_o), 8'h01);
    for (int i = 256; i < 4095; i++) send_byte(8'h00);
    chk("R4", "c8 lo at 4095", int'(c8_pos_lo_o), 8'hFF);
    chk("R9", "c8 hi at 4095", int'(c8_pos_hi_o), 8'h0F);
    for (int i = 0; i < 5; i++) send_byte(8'h00);
    chk("R4", "c8 lo held past 4095", int'(c8_pos_lo_o), 8'hFF);
    chk("R4", "c8 hi held past 4095", int'(c8_pos_hi_o), 8'h0F);
    chk_regs("R4");
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    arst_n = 1'b0; frame_start_i = 1'b0; byte_vld_i = 1'b0;
    byte_i = 8'h00; skip_len_i = 12'h000;
    m_skip = 0;
    model_clear();
    repeat (3) @(negedge clk);
    t_reset();
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ref_known();
    t_crc8_frame();
    t_crc32_header();
    t_skip_zero();
    t_last_correct();
    t_idle();
    t_frame_start();
    t_saturate();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule